// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is an 8-bit down-counter that raises a sticky timer flag each time its count runs out. The counter then restarts from a stored start value. Four periodic tick strobes come in from outside the block, from the fastest rate (4096 Hz) down to one tick per minute. Two bits of a timer-configuration register choose which of them moves the counter, and a third bit of that register enables counting.

A shared interrupt/flag register holds three things: the flag, an interrupt enable, and a mode bit. The mode bit selects whether the interrupt output follows the flag as a level, or gives one short pulse per expiry that lasts about one 64 Hz period.

The host talks to the block through a simple register port. A single-cycle write strobe carries an address and data. Read data is combinational from the same address.

Three addresses are decoded:
- 0x01 is the shared interrupt/flag register.
- 0x0E is the timer configuration.
- 0x0F is the start value. Reading 0x0F returns the live count.

Top module: `countdown_timer`

## Requirements
- R1: After reset, every register and the count are zero, and `irq_o` is low.
- R2: A write to 0x0F stores the data as the start value and loads it into the count in the same cycle. This load takes priority over a tick in that cycle. Reading 0x0F returns the live count.
- R3: The count changes only on a tick of the selected source while enable is set. The select is bits 1:0 of 0x0E (0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz, 3 = per minute) and the enable is bit 3. Ticks of other sources, and all ticks while disabled, leave the count unchanged.
- R4: A selected tick at count 1 sets the flag (bit 2 of 0x01) and reloads the count from the start value. A tick at any larger count decrements it.
- R5: A count of zero never changes on ticks and never sets the flag.
- R6: The flag is cleared only by writing 0x01 with bit 2 low. Writing bit 2 high leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: With the mode bit (bit 4 of 0x01) low, `irq_o` equals the flag AND the interrupt enable (bit 0 of 0x01).
- R8: With the mode bit high, `irq_o` is the interrupt enable AND a pulse. The pulse rises the cycle after an expiry. It falls the cycle after the next 64 Hz tick (source index 1), unless another expiry occurs in that same cycle. The flag still sets as in R4.
- R9: Writes to undecoded addresses change nothing. Undecoded addresses and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | One-cycle tick strobes, index 0 fastest to index 3 slowest |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address, for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_o | output | 1 | Timer interrupt, level or pulse |

## Verification
Every write and every tick takes effect at the clock edge that samples it. So the count, the flag, the read data and `irq_o` each show the new value one cycle after the stimulus. No result takes longer.

The bench drives inputs just after the falling edge and advances a cycle-level reference model at the rising edge. It compares the read data and the interrupt at the next falling edge. Coincident events are aimed at exactly that one-cycle window: a clear during an expiry, a load during an expiry, and an expiry during a 64 Hz tick.

// File: rtl/ct_pkg.sv
package ct_pkg;
    // bit positions inside the interrupt/flag register
    localparam int TIE_BIT   = 0;
    localparam int FLAG_BIT  = 2;
    localparam int PMODE_BIT = 4;
    // bit position of the enable inside the timer configuration
    localparam int EN_BIT    = 3;

    typedef struct packed {
        logic tie;
        logic pmode;
        logic flag;
        logic pulse;
    } irq_st_t;
endpackage

// File: rtl/ct_tick_sel.sv
module ct_tick_sel #(
    parameter int N_SRC = 4,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             en,
    output logic             tick
);
    logic [N_SRC-1:0] hit;

    // one gate per source: pass the strobe only when it is the selected one
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign hit[g] = src_tick[g] && (sel == SEL_W'(g));
    end

    assign tick = en && (|hit);
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic [W-1:0] reload,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rel;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (ld) begin
            // a load always wins over a tick in the same cycle
            st_d.cnt = ld_val;
            st_d.rel = ld_val;
        end else if (tick && (st_q.cnt != '0)) begin
            if (st_q.cnt == W'(1)) begin
                expire   = 1'b1;
                st_d.cnt = st_q.rel;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign reload = st_q.rel;
endmodule

// File: rtl/ct_irq.sv
module ct_irq
    import ct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_tie,
    input  logic cfg_pmode,
    input  logic cfg_keep,
    input  logic expire,
    input  logic slow_tick,
    output logic tie,
    output logic pmode,
    output logic flag,
    output logic pulse,
    output logic irq
);
    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.tie   = cfg_tie;
            st_d.pmode = cfg_pmode;
            if (!cfg_keep) st_d.flag = 1'b0;
        end
        // a new expiry beats a clear in the same cycle
        if (expire) st_d.flag = 1'b1;
        if (expire)         st_d.pulse = 1'b1;
        else if (slow_tick) st_d.pulse = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tie   = st_q.tie;
    assign pmode = st_q.pmode;
    assign flag  = st_q.flag;
    assign pulse = st_q.pulse;
    assign irq   = st_q.tie & (st_q.pmode ? st_q.pulse : st_q.flag);
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
    import ct_pkg::*;
#(
    parameter int N_SRC    = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int SLOW_IDX = 1,
    parameter logic [ADDR_W-1:0] A_CTL = 4'h1,
    parameter logic [ADDR_W-1:0] A_TMR = 4'hE,
    parameter logic [ADDR_W-1:0] A_CNT = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int SEL_W = $clog2(N_SRC);

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } tcfg_t;

    tcfg_t tcfg_d, tcfg_q;

    logic              w_ctl_wr, w_tmr_wr, w_ld, w_tick, w_expire;
    logic              w_tie, w_pmode, w_flag, w_pulse;
    logic [DATA_W-1:0] w_cnt, w_reload;

    assign w_ctl_wr = reg_wr && (reg_addr == A_CTL);
    assign w_tmr_wr = reg_wr && (reg_addr == A_TMR);
    assign w_ld     = reg_wr && (reg_addr == A_CNT);

    always_comb begin
        tcfg_d = tcfg_q;
        if (w_tmr_wr) begin
            tcfg_d.sel = reg_wdata[SEL_W-1:0];
            tcfg_d.en  = reg_wdata[EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tcfg_q <= '0;
        else        tcfg_q <= tcfg_d;
    end

    ct_tick_sel #(.N_SRC(N_SRC)) u_sel (
        .src_tick (src_tick),
        .sel      (tcfg_q.sel),
        .en       (tcfg_q.en),
        .tick     (w_tick)
    );

    ct_counter #(.W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (w_ld),
        .ld_val (reg_wdata),
        .tick   (w_tick),
        .cnt    (w_cnt),
        .reload (w_reload),
        .expire (w_expire)
    );

    ct_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (w_ctl_wr),
        .cfg_tie   (reg_wdata[TIE_BIT]),
        .cfg_pmode (reg_wdata[PMODE_BIT]),
        .cfg_keep  (reg_wdata[FLAG_BIT]),
        .expire    (w_expire),
        .slow_tick (src_tick[SLOW_IDX]),
        .tie       (w_tie),
        .pmode     (w_pmode),
        .flag      (w_flag),
        .pulse     (w_pulse),
        .irq       (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTL) begin
            reg_rdata[TIE_BIT]   = w_tie;
            reg_rdata[FLAG_BIT]  = w_flag;
            reg_rdata[PMODE_BIT] = w_pmode;
        end else if (reg_addr == A_TMR) begin
            reg_rdata[SEL_W-1:0] = tcfg_q.sel;
            reg_rdata[EN_BIT]    = tcfg_q.en;
        end else if (reg_addr == A_CNT) begin
            reg_rdata = w_cnt;
        end
    end
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         expire,
    input logic         flag,
    input logic         pulse,
    input logic [W-1:0] cnt,
    input logic [W-1:0] reload,
    input logic         ld,
    input logic         tick,
    input logic         clr_req
);
    // R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_req));

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !ld) |=> (cnt == '0));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= reload);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld) |=> $stable(cnt));

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(expire));
endmodule

bind countdown_timer ct_checker #(.W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (w_expire),
    .flag    (w_flag),
    .pulse   (w_pulse),
    .cnt     (w_cnt),
    .reload  (w_reload),
    .ld      (w_ld),
    .tick    (w_tick),
    .clr_req (w_ctl_wr && !reg_wdata[ct_pkg::FLAG_BIT])
);

// File: tb/test_countdown_timer.sv
module test_countdown_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_tick = '0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0] m_cnt, m_rel;
    logic [1:0] m_sel;
    logic       m_en, m_tie, m_pm, m_flag, m_pulse;

    always #5 clk = ~clk;

    countdown_timer i_countdown_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (src_tick),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h1:    exp_rd = {3'b0, m_pm, 1'b0, m_flag, 1'b0, m_tie};
            4'hE:    exp_rd = {4'b0, m_en, 1'b0, m_sel};
            4'hF:    exp_rd = m_cnt;
            default: exp_rd = 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq();
        exp_irq = m_tie & (m_pm ? m_pulse : m_flag);
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        case (a)
            4'h1:    rd_tag = "R6 flag reg";
            4'hE:    rd_tag = "R3 cfg reg";
            4'hF:    rd_tag = "R2 count";
            default: rd_tag = "R9 unused";
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_rel = '0; m_sel = '0;
        m_en = 0; m_tie = 0; m_pm = 0; m_flag = 0; m_pulse = 0;
    endtask

    // advance the reference by one clock with the given inputs
    task automatic model_step(input logic [3:0] t, input logic w,
                              input logic [3:0] a, input logic [7:0] d);
        logic tk, ex;
        tk = m_en && t[m_sel];
        ex = 1'b0;
        if (w && a == 4'hF) begin
            m_cnt = d; m_rel = d;
        end else if (tk && m_cnt != 0) begin
            if (m_cnt == 8'd1) begin ex = 1'b1; m_cnt = m_rel; end
            else m_cnt = m_cnt - 8'd1;
        end
        if (w && a == 4'hE) begin m_sel = d[1:0]; m_en = d[3]; end
        if (w && a == 4'h1) begin
            m_tie = d[0]; m_pm = d[4];
            if (!d[2]) m_flag = 1'b0;
        end
        if (ex) m_flag = 1'b1;
        if (ex) m_pulse = 1'b1;
        else if (t[1]) m_pulse = 1'b0;
    endtask

    // one cycle: drive after the falling edge, compare at the next falling edge
    task automatic cyc(input logic [3:0] t, input logic w,
                       input logic [3:0] a, input logic [7:0] d);
        src_tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        model_step(t, w, a, d);
        @(negedge clk);
        chk(rd_tag(a), reg_rdata, exp_rd(a));
        chk("R7/R8 irq", {7'b0, irq_o}, {7'b0, exp_irq()});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(4'b0, 1'b1, a, d);
    endtask

    task automatic peek(input logic [3:0] a, input logic [7:0] e, input string tag);
        cyc(4'b0, 1'b0, a, 8'h00);
        chk(tag, reg_rdata, e);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state during reset
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        reg_addr = 4'hF; #1;
        chk("R1 count", reg_rdata, 8'h00);
        rst_n = 1'b1;
        peek(4'h1, 8'h00, "R1 flag reg");
        peek(4'hE, 8'h00, "R1 cfg reg");

        // R2: load start value
        wr(4'hF, 8'd3);
        peek(4'hF, 8'd3, "R2 load");
        // R3: 1 Hz, enabled
        wr(4'hE, 8'h0A);
        cyc(4'b1011, 1'b0, 4'hF, 8'h00);
        chk("R3 other sources", reg_rdata, 8'd3);
        cyc(4'b0100, 1'b0, 4'hF, 8'h00);
        chk("R4 decrement", reg_rdata, 8'd2);
        cyc(4'b0100, 1'b0, 4'hF, 8'h00);
        chk("R4 decrement", reg_rdata, 8'd1);
        cyc(4'b0100, 1'b0, 4'hF, 8'h00);
        chk("R4 reload", reg_rdata, 8'd3);
        peek(4'h1, 8'h04, "R4 flag set");
        chk("R7 irq off without enable", {7'b0, irq_o}, 8'h00);
        // R6/R7
        wr(4'h1, 8'h05);
        peek(4'h1, 8'h05, "R6 write one keeps flag");
        chk("R7 level irq", {7'b0, irq_o}, 8'h01);
        wr(4'h1, 8'h01);
        peek(4'h1, 8'h01, "R6 clear");
        chk("R7 irq low after clear", {7'b0, irq_o}, 8'h00);
        // R3: disabled
        wr(4'hE, 8'h02);
        cyc(4'b0100, 1'b0, 4'hF, 8'h00);
        chk("R3 disabled hold", reg_rdata, 8'd3);
        // R5: zero start value
        wr(4'hF, 8'd0);
        wr(4'hE, 8'h08);
        repeat (4) cyc(4'b0001, 1'b0, 4'hF, 8'h00);
        chk("R5 zero stays", reg_rdata, 8'd0);
        peek(4'h1, 8'h01, "R5 no flag");
        // R8: pulse mode
        wr(4'hF, 8'd1);
        wr(4'h1, 8'h11);
        cyc(4'b0001, 1'b0, 4'h1, 8'h00);
        chk("R8 pulse high", {7'b0, irq_o}, 8'h01);
        chk("R8 flag also set", reg_rdata, 8'h15);
        repeat (3) cyc(4'b0000, 1'b0, 4'h1, 8'h00);
        chk("R8 pulse held", {7'b0, irq_o}, 8'h01);
        cyc(4'b0010, 1'b0, 4'h1, 8'h00);
        chk("R8 pulse ends", {7'b0, irq_o}, 8'h00);
        chk("R8 flag stays", reg_rdata, 8'h15);
        // R6: clear coincides with expiry
        cyc(4'b0001, 1'b1, 4'h1, 8'h01);
        peek(4'h1, 8'h05, "R6 expiry beats clear");
        // R2: load coincides with expiry
        wr(4'h1, 8'h00);
        cyc(4'b0001, 1'b1, 4'hF, 8'd5);
        peek(4'hF, 8'd5, "R2 load beats tick");
        peek(4'h1, 8'h00, "R2 no expiry on load");
        // R9: undecoded address
        wr(4'h5, 8'hFF);
        peek(4'h5, 8'h00, "R9 unused reads zero");
        peek(4'hE, 8'h08, "R9 cfg unchanged");
        peek(4'hF, 8'd5, "R9 count unchanged");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] t, a;
            logic       w;
            logic [7:0] d;
            t = {($urandom % 64) == 0, ($urandom % 8) == 0,
                 ($urandom % 6) == 0, ($urandom % 2) == 0};
            w = ($urandom % 8) == 0;
            case ($urandom % 4)
                0: a = 4'h1;
                1: a = 4'hE;
                2: a = 4'hF;
                default: a = 4'($urandom);
            endcase
            d = (a == 4'hF) ? 8'($urandom % 4) : 8'($urandom);
            if (a == 4'hE && ($urandom % 4) != 0) d[3] = 1'b1;
            cyc(t, w, a, d);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule